// File: doc/BRIEF.md
# Durable transaction state sequencer

This block steps a single hardware transaction through its lifecycle. The core raises a begin strobe to open the transaction and an end strobe to close it. A conflict or overflow indication from the coherence side kills the transaction at any point before it has committed. Durability has two stages. First the log path must report that every redo log record is persistent. At that point the transaction counts as committed: its speculative writes become non-speculative and the write-back of in-place data is started. Only when the write-back path reports that the in-place data is also persistent does the transaction complete. This split keeps the in-place updates off the commit critical path.

On the end strobe the sequencer asks the log buffer to flush. It then waits in a pending state until the log acknowledgment arrives, unless that acknowledgment comes in the same cycle as the end strobe. The abort strobe tells the cache to discard the write set. The commit strobe and the write-back start pulse are each issued once per committed transaction. The sequencer only orders these events; the log and write-back datapaths sit outside it.

Top module: `durable_tx_seq`

## Requirements
- R1: After reset the state output is 0 (idle) and flush request, commit, write-back start and abort are all low.
- R2: A begin strobe in idle moves the state to 1 (active) on the next clock edge. A begin strobe in any other state has no effect.
- R3: In active, a conflict moves the state to 5 (abort) on the next edge. This takes priority over a simultaneous end strobe.
- R4: In active, an end strobe without a log acknowledgment moves the state to 2 (log pending). The flush request output is high in exactly the cycles spent in state 2.
- R5: A log acknowledgment moves the state to 3 (committed) on the next edge, either from state 2 or from active when it arrives together with the end strobe.
- R6: In state 2, a conflict moves the state to 5. This takes priority over a simultaneous log acknowledgment.
- R7: The commit and write-back start outputs are high only in the first cycle of state 3. While in state 3, conflict, begin, end and log acknowledgment have no effect.
- R8: In state 3, an in-place acknowledgment moves the state to 4 (complete).
- R9: States 4 and 5 each last one cycle and then return to 0. The abort output is high exactly while the state is 5.
- R10: Acknowledgments and end strobes arriving in a state that does not wait for them have no effect. This covers end in idle, either acknowledgment in idle or active, and an in-place acknowledgment in state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin_i | input | 1 | Begin-transaction strobe from the core |
| tx_end_i | input | 1 | End-transaction strobe from the core |
| conflict_i | input | 1 | Conflict or overflow indication |
| log_done_i | input | 1 | All log records persistent |
| inplace_done_i | input | 1 | In-place data persistent |
| state_o | output | 3 | Current state (0 idle, 1 active, 2 log pending, 3 committed, 4 complete, 5 abort) |
| log_flush_o | output | 1 | Flush request to the log buffer |
| commit_o | output | 1 | Commit strobe |
| wb_start_o | output | 1 | Start of in-place write-back |
| abort_o | output | 1 | Abort strobe |

## Verification
The hardest cases to reach are races at the two waiting states. A conflict can collide with a log acknowledgment in the log pending state. Stray conflicts and strobes can arrive once the transaction has committed. The bench drives the sequencer into each of its six states through a short legal prefix. In that state it applies all 32 combinations of the five inputs for one cycle. It then checks the resulting state and strobes against a transition model derived from the requirements, and checks once more after a quiet cycle.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_ACTIVE  = 3'd1,
        ST_LOGWAIT = 3'd2,
        ST_COMMIT  = 3'd3,
        ST_DONE    = 3'd4,
        ST_ABORT   = 3'd5
    } tx_state_e;

    typedef struct packed {
        tx_state_e st;
    } ctrl_regs_t;

    typedef struct packed {
        tx_state_e prev;
    } strobe_regs_t;
endpackage

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl
    import tx_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      begin_i,
    input  logic      end_i,
    input  logic      conflict_i,
    input  logic      log_done_i,
    input  logic      inplace_done_i,
    output tx_state_e state_o
);
    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE:
                if (begin_i) r_d.st = ST_ACTIVE;
            ST_ACTIVE:
                if (conflict_i)               r_d.st = ST_ABORT;
                else if (end_i && log_done_i) r_d.st = ST_COMMIT;
                else if (end_i)               r_d.st = ST_LOGWAIT;
            ST_LOGWAIT:
                if (conflict_i)      r_d.st = ST_ABORT;
                else if (log_done_i) r_d.st = ST_COMMIT;
            ST_COMMIT:
                if (inplace_done_i) r_d.st = ST_DONE;
            ST_DONE:  r_d.st = ST_IDLE;
            ST_ABORT: r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE};
        else        r_q <= r_d;
    end

    assign state_o = r_q.st;

    AST_ABORT_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ABORT) |-> ($past(r_q.st) == ST_ACTIVE || $past(r_q.st) == ST_LOGWAIT)); // R6
    AST_ACTIVE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACTIVE) |-> ($past(r_q.st) == ST_IDLE || $past(r_q.st) == ST_ACTIVE)); // R2
    AST_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_COMMIT && !inplace_done_i) |=> (r_q.st == ST_COMMIT)); // R7
    AST_ONE_CYCLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DONE || r_q.st == ST_ABORT) |=> (r_q.st == ST_IDLE)); // R9
    AST_DONE_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DONE) |-> ($past(r_q.st) == ST_COMMIT)); // R8
endmodule

// File: rtl/tx_seq_strobes.sv
module tx_seq_strobes
    import tx_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tx_state_e state_i,
    output logic      flush_o,
    output logic      commit_o,
    output logic      wb_start_o,
    output logic      abort_o
);
    strobe_regs_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = state_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{prev: ST_IDLE};
        else        s_q <= s_d;
    end

    logic enter_commit;
    assign enter_commit = (state_i == ST_COMMIT) && (s_q.prev != ST_COMMIT);
    assign flush_o      = (state_i == ST_LOGWAIT);
    assign commit_o     = enter_commit;
    assign wb_start_o   = enter_commit;
    assign abort_o      = (state_i == ST_ABORT);

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o); // R7
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_start_o |=> !wb_start_o); // R7
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o); // R9
endmodule

// File: rtl/durable_tx_seq.sv
module durable_tx_seq
    import tx_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_begin_i,
    input  logic            tx_end_i,
    input  logic            conflict_i,
    input  logic            log_done_i,
    input  logic            inplace_done_i,
    output logic [ST_W-1:0] state_o,
    output logic            log_flush_o,
    output logic            commit_o,
    output logic            wb_start_o,
    output logic            abort_o
);
    tx_state_e st;

    tx_seq_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .begin_i        (tx_begin_i),
        .end_i          (tx_end_i),
        .conflict_i     (conflict_i),
        .log_done_i     (log_done_i),
        .inplace_done_i (inplace_done_i),
        .state_o        (st)
    );

    tx_seq_strobes u_strobes (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (st),
        .flush_o    (log_flush_o),
        .commit_o   (commit_o),
        .wb_start_o (wb_start_o),
        .abort_o    (abort_o)
    );

    assign state_o = st;

    AST_FLUSH_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (log_flush_o && !log_done_i && !conflict_i) |=> log_flush_o); // R4
endmodule

// File: tb/durable_tx_seq_tb_top.sv
module durable_tx_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b = 1'b0, e = 1'b0, c = 1'b0, la = 1'b0, ia = 1'b0;
    logic [2:0] st;
    logic flush, commit, wbs, abrt;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    durable_tx_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tx_begin_i(b), .tx_end_i(e),
        .conflict_i(c), .log_done_i(la), .inplace_done_i(ia),
        .state_o(st), .log_flush_o(flush), .commit_o(commit),
        .wb_start_o(wbs), .abort_o(abrt)
    );

    function automatic logic [2:0] model_next(input logic [2:0] s, input logic [4:0] v);
        logic vb, ve, vc, vl, vi;
        {vb, ve, vc, vl, vi} = v;
        case (s)
            3'd0: return vb ? 3'd1 : 3'd0;                    // R2, R10
            3'd1: if (vc) return 3'd5;                        // R3
                  else if (ve && vl) return 3'd3;             // R5
                  else if (ve) return 3'd2;                   // R4
                  else return 3'd1;
            3'd2: if (vc) return 3'd5;                        // R6
                  else if (vl) return 3'd3;                   // R5
                  else return 3'd2;
            3'd3: return vi ? 3'd4 : 3'd3;                    // R7, R8
            default: return 3'd0;                             // R9
        endcase
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b (state,flush,commit,wb,abort)", req, act, exp);
        end
    endtask

    function automatic logic [6:0] expect_outs(input logic [2:0] s, input logic [2:0] prev);
        logic ent;
        ent = (s == 3'd3) && (prev != 3'd3);
        return {s, s == 3'd2, ent, ent, s == 3'd5};
    endfunction

    task automatic step(input logic [4:0] v);
        {b, e, c, la, ia} = v;
        @(negedge clk);
        {b, e, c, la, ia} = 5'b0;
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        {b, e, c, la, ia} = 5'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic go_to(input logic [2:0] s);
        case (s)
            3'd1: step(5'b10000);
            3'd2: begin step(5'b10000); step(5'b01000); end
            3'd3: begin step(5'b10000); step(5'b01010); end
            3'd4: begin step(5'b10000); step(5'b01010); step(5'b00001); end
            3'd5: begin step(5'b10000); step(5'b00100); end
            default: ;
        endcase
    endtask

    initial begin
        reset_dut();
        check("R1 reset", {st, flush, commit, wbs, abrt}, 7'b0);
        for (int s = 0; s < 6; s++) begin
            for (int v = 0; v < 32; v++) begin
                logic [2:0] prev_s, nx, nx2;
                reset_dut();
                go_to(3'(s));
                prev_s = st;
                check("R2 R4 R5 R8 setup state", {st, 4'b0} | {4'b0, flush, commit, wbs, abrt} & 7'b0, {3'(s), 4'b0});
                nx = model_next(3'(s), 5'(v));
                step(5'(v));
                check("R2 R3 R4 R5 R6 R7 R8 R9 R10 transition",
                      {st, flush, commit, wbs, abrt}, expect_outs(nx, prev_s));
                nx2 = model_next(nx, 5'b0);
                step(5'b0);
                check("R4 R7 R9 quiet follow-up",
                      {st, flush, commit, wbs, abrt}, expect_outs(nx2, nx));
            end
        end
        // full commit sequence with a long write-back wait, R7 strobe single cycle
        reset_dut();
        step(5'b10000);
        step(5'b01000);
        check("R4 flush in pending", {st, flush, commit, wbs, abrt}, 7'b0101000);
        step(5'b00010);
        check("R5 R7 commit entry", {st, flush, commit, wbs, abrt}, 7'b0110110);
        for (int k = 0; k < 4; k++) begin
            step(5'b11110);
            check("R7 commit ignores stray inputs", {st, flush, commit, wbs, abrt}, 7'b0110000);
        end
        step(5'b00001);
        check("R8 complete", {st, flush, commit, wbs, abrt}, 7'b1000000);
        step(5'b0);
        check("R9 back to idle", {st, flush, commit, wbs, abrt}, 7'b0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule